// File: doc/BRIEF.md
# Decade Counter with Per-Bit Clock Gating

This block is a decimal counter that steps through the digits 0 to 9 and then returns to 0. It advances once per rising edge of `clk` while `cnt_en` is high, and holds its value while `cnt_en` is low. It is built for low switching activity. Each of the four state flip-flops has its own gated clock, and a bit receives a rising edge only on a cycle where its value is about to change. A bit that keeps its value receives no edge and simply retains its content.

A step decoder computes the next digit and a per-bit change mask. The digit is an enumerated state, `DIGIT_0` to `DIGIT_9`, and every transition goes from `DIGIT_n` to `DIGIT_n+1`, except `DIGIT_9`, which goes to `DIGIT_0`. Each bit of the mask drives a glitch-free clock gate. The gate uses a latch that is transparent while `clk` is low, and the latch output is ANDed with `clk`. Synchronous reset opens all four gates so that the clear reaches every bit.

A tally output accumulates the number of bit-clock edges actually delivered. It is intended for verification of the gating behaviour.

Top module: `bcd_gated_counter`

## Requirements
- R1: With `rst` high at a rising `clk` edge, the next `count` is 0 and `evt_total` is 0, whatever the previous state.
- R2: With `cnt_en` high at a rising edge, `count` moves from n to n+1 for n in 0..8, and from 9 to 0.
- R3: With `cnt_en` low at a rising edge, `count` is unchanged and `evt_total` does not increase, because no bit clock pulses.
- R4: On every enabled step, `evt_total` grows by exactly the number of bits of `count` that change. A bit is clocked only on a step where its next value differs from its current value.
- R5: The step 2 to 3 adds exactly 1 event (bit 0 only). The step 7 to 8 adds 4 events. The step 9 to 0 adds 2 events. Bit 3 is clocked only on the 7 to 8 and 9 to 0 steps.
- R6: A full run of ten enabled steps from 0 back to 0 delivers 18 bit-clock events, fewer than half of the 40 events that an ungated four-bit register would receive.
- R7: `count` never holds a value above 9 after reset.
- R8: `evt_total` is an unsigned count that wraps modulo 2^EVT_W.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Free-running clock; all state changes on its rising edge |
| rst | input | 1 | Synchronous reset, active high; forces all bit gates open |
| cnt_en | input | 1 | Count enable, sampled at the rising edge |
| count | output | 4 | Current digit, binary coded 0 to 9 |
| evt_total | output | EVT_W | Running total of delivered bit-clock edges |

## Verification
The bound checker watches the following on every cycle:
- `count` steps correctly, by increment or by the 9-to-0 wrap, whenever `cnt_en` is high.
- Both outputs stay frozen whenever `cnt_en` is low.
- `count` stays within 0 to 9.
- Each cycle's growth in the event total equals the Hamming distance between successive counts, which ties the gated clocks to the bits that really moved.

The bench scenarios show the fixed per-step event counts of R5 and the 18-event total of a whole decade. They also show clearing from an arbitrary mid-count state, and long random enable patterns compared against a reference decade counter.

// File: rtl/bcdg_pkg.sv
package bcdg_pkg;

    localparam int DIGIT_W = 4;

    typedef enum logic [DIGIT_W-1:0] {
        DIGIT_0 = 4'd0,
        DIGIT_1 = 4'd1,
        DIGIT_2 = 4'd2,
        DIGIT_3 = 4'd3,
        DIGIT_4 = 4'd4,
        DIGIT_5 = 4'd5,
        DIGIT_6 = 4'd6,
        DIGIT_7 = 4'd7,
        DIGIT_8 = 4'd8,
        DIGIT_9 = 4'd9
    } digit_e;

endpackage

// File: rtl/bcdg_step_logic.sv
module bcdg_step_logic
    import bcdg_pkg::*;
(
    input  logic [DIGIT_W-1:0] cur,
    input  logic               cnt_en,
    input  logic               rst,
    output logic [DIGIT_W-1:0] nxt,
    output logic [DIGIT_W-1:0] bit_en
);

    digit_e succ;

    // Transition table of the digit state machine
    always_comb begin
        unique case (cur)
            DIGIT_0: succ = DIGIT_1;
            DIGIT_1: succ = DIGIT_2;
            DIGIT_2: succ = DIGIT_3;
            DIGIT_3: succ = DIGIT_4;
            DIGIT_4: succ = DIGIT_5;
            DIGIT_5: succ = DIGIT_6;
            DIGIT_6: succ = DIGIT_7;
            DIGIT_7: succ = DIGIT_8;
            DIGIT_8: succ = DIGIT_9;
            DIGIT_9: succ = DIGIT_0;
            default: succ = DIGIT_0;
        endcase
    end

    // Reset opens every gate and loads zero; otherwise only changing bits are enabled
    always_comb begin
        if (rst) begin
            nxt    = '0;
            bit_en = '1;
        end else begin
            nxt    = succ;
            bit_en = cnt_en ? (succ ^ cur) : '0;
        end
    end

endmodule

// File: rtl/bcdg_clock_gate.sv
module bcdg_clock_gate (
    input  logic clk,
    input  logic en,
    output logic gclk,
    output logic open
);

    logic en_lat;

    // Transparent in the low phase, so the enable is frozen during the high phase
    always_latch begin
        if (!clk) begin
            en_lat <= en;
        end
    end

    assign gclk = clk & en_lat;
    assign open = en_lat;

endmodule

// File: rtl/bcdg_bit_cell.sv
module bcdg_bit_cell (
    input  logic gclk,
    input  logic d,
    output logic q
);

    always_ff @(posedge gclk) begin
        q <= d;
    end

endmodule

// File: rtl/bcdg_event_tally.sv
module bcdg_event_tally #(
    parameter int LANES = 4,
    parameter int EVT_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [LANES-1:0] fired,
    output logic [EVT_W-1:0] total
);

    localparam int INC_W = $clog2(LANES + 1);

    logic [INC_W-1:0] inc;

    always_comb begin
        inc = '0;
        for (int i = 0; i < LANES; i++) begin
            inc = inc + INC_W'(fired[i]);
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            total <= '0;
        end else begin
            total <= total + EVT_W'(inc);
        end
    end

endmodule

// File: rtl/bcd_gated_counter.sv
module bcd_gated_counter
    import bcdg_pkg::*;
#(
    parameter int EVT_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             cnt_en,
    output logic [3:0]       count,
    output logic [EVT_W-1:0] evt_total
);

    logic [DIGIT_W-1:0] cur_q;
    logic [DIGIT_W-1:0] nxt;
    logic [DIGIT_W-1:0] bit_en;
    logic [DIGIT_W-1:0] gclk;
    logic [DIGIT_W-1:0] gate_open;

    bcdg_step_logic u_step (
        .cur    (cur_q),
        .cnt_en (cnt_en),
        .rst    (rst),
        .nxt    (nxt),
        .bit_en (bit_en)
    );

    // State register: one gated flip-flop per bit
    for (genvar i = 0; i < DIGIT_W; i++) begin : g_bit
        bcdg_clock_gate u_gate (
            .clk  (clk),
            .en   (bit_en[i]),
            .gclk (gclk[i]),
            .open (gate_open[i])
        );
        bcdg_bit_cell u_cell (
            .gclk (gclk[i]),
            .d    (nxt[i]),
            .q    (cur_q[i])
        );
    end

    // Outputs: digit and delivered-edge tally
    bcdg_event_tally #(
        .LANES (DIGIT_W),
        .EVT_W (EVT_W)
    ) u_tally (
        .clk   (clk),
        .rst   (rst),
        .fired (gate_open),
        .total (evt_total)
    );

    assign count = cur_q;

endmodule

// File: rtl/bcdg_checker.sv
module bcdg_checker #(
    parameter int EVT_W = 16
) (
    input logic             clk,
    input logic             rst,
    input logic             cnt_en,
    input logic [3:0]       count,
    input logic [EVT_W-1:0] evt_total
);

    a_r2_increment: assert property (@(posedge clk) disable iff (rst)
        (cnt_en && count < 4'd9) |=> (count == $past(count) + 4'd1));

    a_r2_wrap: assert property (@(posedge clk) disable iff (rst)
        (cnt_en && count == 4'd9) |=> (count == 4'd0));

    a_r3_hold_count: assert property (@(posedge clk) disable iff (rst)
        !cnt_en |=> $stable(count));

    a_r3_no_events: assert property (@(posedge clk) disable iff (rst)
        !cnt_en |=> $stable(evt_total));

    a_r4_events_match_toggles: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> (evt_total == $past(evt_total)
                  + EVT_W'($countones(count ^ $past(count)))));

    a_r7_legal_digit: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> (count <= 4'd9));

endmodule

bind bcd_gated_counter bcdg_checker #(
    .EVT_W (EVT_W)
) u_chk (
    .clk       (clk),
    .rst       (rst),
    .cnt_en    (cnt_en),
    .count     (count),
    .evt_total (evt_total)
);

// File: tb/bcd_gated_counter_test.sv
module bcd_gated_counter_test;

    localparam int EVT_W = 16;

    logic             clk = 1'b0;
    logic             rst = 1'b1;
    logic             cnt_en = 1'b0;
    logic [3:0]       count;
    logic [EVT_W-1:0] evt_total;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    logic [3:0]       exp_cnt = '0;
    logic [EVT_W-1:0] exp_evt = '0;

    bcd_gated_counter #(.EVT_W(EVT_W)) uut (
        .clk       (clk),
        .rst       (rst),
        .cnt_en    (cnt_en),
        .count     (count),
        .evt_total (evt_total)
    );

    always #5 clk = ~clk;

    function automatic logic [3:0] ref_next(input logic [3:0] v);
        return (v == 4'd9) ? 4'd0 : v + 4'd1;
    endfunction

    function automatic int flips(input logic [3:0] a, input logic [3:0] b);
        int n = 0;
        for (int i = 0; i < 4; i++) n += (a[i] != b[i]) ? 1 : 0;
        return n;
    endfunction

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // One rising edge with the given inputs, then model update and compare
    task automatic step(input logic en, input logic r, input string req);
        @(negedge clk);
        cnt_en = en;
        rst    = r;
        @(posedge clk);
        #1;
        if (r) begin
            exp_cnt = '0;
            exp_evt = '0;
        end else if (en) begin
            exp_evt = exp_evt + EVT_W'(flips(exp_cnt, ref_next(exp_cnt)));
            exp_cnt = ref_next(exp_cnt);
        end
        check(req, 32'(count), 32'(exp_cnt));
        check(req, 32'(evt_total), 32'(exp_evt));
    endtask

    task automatic run_to(input logic [3:0] target);
        while (exp_cnt != target) step(1'b1, 1'b0, "R2");
    endtask

    task automatic summary();
        if (!done) begin
            done = 1'b1;
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    endtask

    initial begin
        #2_000_000;
        errors++;
        $display("FAIL watchdog actual=timeout expected=finish");
        summary();
    end

    initial begin
        logic [EVT_W-1:0] base;
        int seed_init;
        seed_init = $urandom(32'd20240611);

        // R1: reset state
        step(1'b0, 1'b1, "R1");
        step(1'b0, 1'b1, "R1");

        // R6: full decade delivers 18 events
        base = evt_total;
        for (int k = 0; k < 10; k++) step(1'b1, 1'b0, "R2");
        check("R6", 32'(count), 32'd0);
        check("R6", 32'(evt_total - base), 32'd18);

        // R5: 2 to 3 only bit 0
        run_to(4'd2);
        base = evt_total;
        step(1'b1, 1'b0, "R5");
        check("R5", 32'(evt_total - base), 32'd1);

        // R5: 7 to 8 all four bits; 9 to 0 two bits
        run_to(4'd7);
        base = evt_total;
        step(1'b1, 1'b0, "R5");
        check("R5", 32'(evt_total - base), 32'd4);
        step(1'b1, 1'b0, "R5");
        base = evt_total;
        step(1'b1, 1'b0, "R5");
        check("R5", 32'(evt_total - base), 32'd2);

        // R3: hold with enable low
        run_to(4'd6);
        base = evt_total;
        for (int k = 0; k < 5; k++) step(1'b0, 1'b0, "R3");
        check("R3", 32'(count), 32'd6);
        check("R3", 32'(evt_total - base), 32'd0);

        // R1: mid-count reset clears both outputs
        run_to(4'd8);
        step(1'b1, 1'b1, "R1");

        // R2 R4 R7: random enable pattern against the reference counter
        for (int k = 0; k < 400; k++) begin
            step(1'($urandom_range(0, 3) != 0), 1'b0, "R4");
            check("R7", 32'(count <= 4'd9), 32'd1);
        end

        // R8: tally wraps modulo 2^EVT_W (run long enough to pass 65535)
        while (exp_evt < EVT_W'(65530)) step(1'b1, 1'b0, "R8");
        for (int k = 0; k < 12; k++) step(1'b1, 1'b0, "R8");

        summary();
    end

endmodule